// File: doc/BRIEF.md
# Per-channel ADC offset and gain corrector

This block sits between a multi-channel conversion engine and the host interface. It applies system calibration to a stream of signed 24-bit conversion results. Each result arrives with a channel tag and a valid strobe. The block first removes that channel's programmed offset word. It then scales the difference by that channel's programmed gain word and emits the corrected result, keeping the same channel tag.

Correction is always applied and cannot be bypassed. Calibration words are held in volatile registers. After reset they take values that leave the data unchanged, and the host must reload them after every reset.

Each 24-bit word is written as a 16-bit upper half followed by a lower byte. The word only changes when the lower byte is written, so the datapath never sees a half-updated coefficient.

Top module: `adc_cal_corrector`

## Requirements
- R1: After reset every offset word is 000000h and every gain word is 800000h, so each sample comes out equal to its input value.
- R2: Each channel has its own offset word and its own gain word. A write to one channel does not change the results of any other channel.
- R3: The offset word is a 24-bit two's complement value. It is subtracted from the sample at 25-bit width before any scaling, so the difference never wraps.
- R4: The gain word is an unsigned factor of code / 2^23. Code 000000h gives 0, code 800000h gives exactly 1, and code FFFFFFh gives just under 2.
- R5: The scaled product is shifted right by 23 with round-half-up, meaning floor(x + 0.5). For example, 1.5 rounds to 2 and -1.5 rounds to -1.
- R6: A result above 7FFFFFh becomes 7FFFFFh, and a result below 800000h (-2^23) becomes 800000h.
- R7: The write address is {channel, kind, half}. Bit 0 is the half: 0 for the upper half, 1 for the lower half. Bit 1 is the kind: 0 for offset, 1 for gain. The bits above those hold the channel. An upper-half write stages bits [23:8] from wr_data[15:0] and changes nothing the datapath uses. A lower-half write loads {staged upper, wr_data[15:8]} into the word.
- R8: A lower-half write in the same cycle as a sample on the same channel does not affect that sample. It takes effect from the next sample.
- R9: out_valid rises exactly two clocks after in_valid, only for accepted samples. out_chan equals the tag of that sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_chan | input | 2 | Input channel tag |
| in_data | input | 24 | Raw signed conversion result |
| wr_en | input | 1 | Coefficient write strobe |
| wr_addr | input | 4 | {channel, kind, half} |
| wr_data | input | 16 | Coefficient half data |
| out_valid | output | 1 | Corrected sample strobe |
| out_chan | output | 2 | Channel tag of the corrected sample |
| out_data | output | 24 | Corrected signed result |

## Verification
A vector table covers several input patterns, each with its own purpose:
- Unity gain with nonzero offsets shows that the subtraction works.
- Half and near-double gains separate the effect of the gain from the effect of the offset.
- Odd inputs at half gain land exactly on .5 in both signs, which separates round-half-up from truncation and from rounding away from zero.
- Extreme values with a large offset push the result past both limits, which separates saturation from wraparound and shows that the 25-bit difference does not wrap.

Directed tests cover three further cases:
- A lone upper-half write, followed later by the lower-half write, shows when a word actually changes.
- A lower-half write in the same cycle as a sample on the same channel shows that the new value is taken from the next sample.
- Back-to-back samples on different channels check the latency and the tag. A reset between runs shows that the coefficients return to pass-through values.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  localparam int unsigned CH_N  = 4;
  localparam int unsigned DW    = 24;
  localparam int unsigned RW    = 16;
  localparam int unsigned FRAC  = 23;
  localparam int unsigned CHW   = (CH_N > 1) ? $clog2(CH_N) : 1;
  localparam int unsigned AW    = CHW + 2;

  typedef enum logic { HALF_UPPER = 1'b0, HALF_LOWER = 1'b1 } half_e;
  typedef enum logic { KIND_OFFSET = 1'b0, KIND_GAIN = 1'b1 } kind_e;

  localparam logic [DW-1:0] OFFSET_RESET = '0;
  localparam logic [DW-1:0] GAIN_RESET   = DW'(1) << FRAC;
endpackage

// File: rtl/adc_cal_coef_bank.sv
module adc_cal_coef_bank #(
  parameter int unsigned CH_N = 4,
  parameter int unsigned DW   = 24,
  parameter int unsigned RW   = 16,
  parameter logic [DW-1:0] RST_WORD = '0,
  localparam int unsigned CHW = (CH_N > 1) ? $clog2(CH_N) : 1,
  localparam int unsigned LOW = DW - RW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [CHW-1:0]     wr_chan,
  input  logic               wr_lower,
  input  logic [RW-1:0]      wr_data,
  input  logic [CHW-1:0]     rd_chan,
  output logic [DW-1:0]      rd_word,
  output logic [CH_N*DW-1:0] all_words
);
  logic [RW-1:0] stage_q [CH_N];
  logic [DW-1:0] word_q  [CH_N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < CH_N; c++) begin
        stage_q[c] <= RST_WORD[DW-1 -: RW];
        word_q[c]  <= RST_WORD;
      end
    end else if (wr_en) begin
      for (int c = 0; c < CH_N; c++) begin
        if (wr_chan == CHW'(c)) begin
          if (!wr_lower) stage_q[c] <= wr_data;
          else           word_q[c]  <= {stage_q[c], wr_data[RW-1 -: LOW]};
        end
      end
    end
  end

  assign rd_word = word_q[rd_chan];

  for (genvar g = 0; g < CH_N; g++) begin : g_flat
    assign all_words[g*DW +: DW] = word_q[g];
  end
endmodule

// File: rtl/adc_cal_sub_stage.sv
module adc_cal_sub_stage #(
  parameter int unsigned DW  = 24,
  parameter int unsigned CHW = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [CHW-1:0]       in_chan,
  input  logic [DW-1:0]        in_data,
  input  logic [DW-1:0]        offset_word,
  input  logic [DW-1:0]        gain_word,
  output logic                 s1_valid,
  output logic [CHW-1:0]       s1_chan,
  output logic signed [DW:0]   s1_diff,
  output logic [DW-1:0]        s1_gain
);
  logic signed [DW:0] diff_c;

  always_comb begin
    diff_c = $signed({in_data[DW-1], in_data}) - $signed({offset_word[DW-1], offset_word});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_chan  <= '0;
      s1_diff  <= '0;
      s1_gain  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_chan <= in_chan;
        s1_diff <= diff_c;
        s1_gain <= gain_word;
      end
    end
  end
endmodule

// File: rtl/adc_cal_mul_stage.sv
module adc_cal_mul_stage #(
  parameter int unsigned DW   = 24,
  parameter int unsigned GW   = 24,
  parameter int unsigned FRAC = 23,
  parameter int unsigned CHW  = 2,
  localparam int unsigned PW  = DW + GW + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               s1_valid,
  input  logic [CHW-1:0]     s1_chan,
  input  logic signed [DW:0] s1_diff,
  input  logic [GW-1:0]      s1_gain,
  output logic               out_valid,
  output logic [CHW-1:0]     out_chan,
  output logic [DW-1:0]      out_data
);
  localparam logic signed [PW-1:0] HALF_LSB = $signed(PW'(1) << (FRAC - 1));
  localparam logic signed [PW-1:0] MAX_V = $signed({{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}});
  localparam logic signed [PW-1:0] MIN_V = $signed({{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}});

  logic signed [PW-1:0] diff_x, gain_x, prod_c, rnd_c, shf_c, sat_c;

  always_comb begin
    diff_x = $signed({{(PW-DW-1){s1_diff[DW]}}, s1_diff});
    gain_x = $signed({{(PW-GW){1'b0}}, s1_gain});
    prod_c = diff_x * gain_x;
    rnd_c  = prod_c + HALF_LSB;
    shf_c  = rnd_c >>> FRAC;
    if (shf_c > MAX_V)      sat_c = MAX_V;
    else if (shf_c < MIN_V) sat_c = MIN_V;
    else                    sat_c = shf_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_chan <= s1_chan;
        out_data <= sat_c[DW-1:0];
      end
    end
  end
endmodule

// File: rtl/adc_cal_corrector.sv
module adc_cal_corrector
  import adc_cal_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [CHW-1:0] in_chan,
  input  logic [DW-1:0]  in_data,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [RW-1:0]  wr_data,
  output logic           out_valid,
  output logic [CHW-1:0] out_chan,
  output logic [DW-1:0]  out_data
);
  logic [CHW-1:0]     wr_chan;
  half_e              wr_half;
  kind_e              wr_kind;
  logic               off_wr, gain_wr;
  logic [DW-1:0]      offset_word, gain_word;
  logic [CH_N*DW-1:0] offset_flat, gain_flat;
  logic               s1_valid;
  logic [CHW-1:0]     s1_chan;
  logic signed [DW:0] s1_diff;
  logic [DW-1:0]      s1_gain;

  assign wr_chan = wr_addr[AW-1:2];
  assign wr_kind = kind_e'(wr_addr[1]);
  assign wr_half = half_e'(wr_addr[0]);
  assign off_wr  = wr_en && (wr_kind == KIND_OFFSET);
  assign gain_wr = wr_en && (wr_kind == KIND_GAIN);

  adc_cal_coef_bank #(.CH_N(CH_N), .DW(DW), .RW(RW), .RST_WORD(OFFSET_RESET)) off_bank_i (
    .clk(clk), .rst(rst), .wr_en(off_wr), .wr_chan(wr_chan),
    .wr_lower(wr_half == HALF_LOWER), .wr_data(wr_data),
    .rd_chan(in_chan), .rd_word(offset_word), .all_words(offset_flat)
  );

  adc_cal_coef_bank #(.CH_N(CH_N), .DW(DW), .RW(RW), .RST_WORD(GAIN_RESET)) gain_bank_i (
    .clk(clk), .rst(rst), .wr_en(gain_wr), .wr_chan(wr_chan),
    .wr_lower(wr_half == HALF_LOWER), .wr_data(wr_data),
    .rd_chan(in_chan), .rd_word(gain_word), .all_words(gain_flat)
  );

  adc_cal_sub_stage #(.DW(DW), .CHW(CHW)) sub_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan), .in_data(in_data),
    .offset_word(offset_word), .gain_word(gain_word),
    .s1_valid(s1_valid), .s1_chan(s1_chan), .s1_diff(s1_diff), .s1_gain(s1_gain)
  );

  adc_cal_mul_stage #(.DW(DW), .GW(DW), .FRAC(FRAC), .CHW(CHW)) mul_i (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_chan(s1_chan),
    .s1_diff(s1_diff), .s1_gain(s1_gain),
    .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data)
  );
endmodule

// File: rtl/adc_cal_corrector_chk.sv
module adc_cal_corrector_chk
  import adc_cal_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [CHW-1:0] in_chan,
  input logic           wr_en,
  input logic [AW-1:0]  wr_addr,
  input logic           out_valid,
  input logic [CHW-1:0] out_chan,
  input logic [CH_N*DW-1:0] offset_flat,
  input logic [CH_N*DW-1:0] gain_flat
);
  localparam logic [CH_N*DW-1:0] GAIN_ALL = {CH_N{GAIN_RESET}};

  a_r9_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  a_r9_tag: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_chan == $past(in_chan, 2));

  a_r7_upper_no_effect: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr[0]) |=> ($stable(offset_flat) && $stable(gain_flat)));

  a_r1_reset_defaults: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (offset_flat == '0 && gain_flat == GAIN_ALL));
endmodule

bind adc_cal_corrector adc_cal_corrector_chk chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
  .wr_en(wr_en), .wr_addr(wr_addr), .out_valid(out_valid), .out_chan(out_chan),
  .offset_flat(offset_flat), .gain_flat(gain_flat)
);

// File: tb/adc_cal_corrector_tb_top.sv
module adc_cal_corrector_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  in_chan;
  logic [23:0] in_data;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic        out_valid;
  logic [1:0]  out_chan;
  logic [23:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  adc_cal_corrector dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan), .in_data(in_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data)
  );

  localparam int NV = 8;
  // {raw, offset, gain}
  localparam logic [71:0] VEC [NV] = '{
    {24'h001000, 24'h000100, 24'h800000},
    {24'hFFF000, 24'h000010, 24'h800000},
    {24'h000003, 24'h000000, 24'h400000},
    {24'hFFFFFD, 24'h000000, 24'h400000},
    {24'h400000, 24'h000000, 24'hFFFFFF},
    {24'h800000, 24'h7FFFFF, 24'h800000},
    {24'h7FFFFF, 24'h800000, 24'h000001},
    {24'h123456, 24'h000000, 24'h000000}
  };

  function automatic logic [23:0] model(logic [23:0] raw, logic [23:0] off, logic [23:0] g);
    longint d, p, r;
    d = longint'($signed(raw)) - longint'($signed(off));
    p = d * longint'({40'd0, g});
    r = (p + 64'sd4194304) >>> 23;
    if (r > 64'sd8388607) r = 64'sd8388607;
    if (r < -64'sd8388608) r = -64'sd8388608;
    return r[23:0];
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_coef(logic [1:0] ch, bit kind, logic [23:0] v);
    wr({ch, kind, 1'b0}, v[23:8]);
    wr({ch, kind, 1'b1}, {v[7:0], 8'h00});
  endtask

  // Drive one sample at a falling edge, return its result two rising edges later.
  task automatic run(logic [1:0] ch, logic [23:0] d, output logic [23:0] res, output logic [1:0] rch, output bit vld1, output bit vld2);
    in_valid = 1'b1; in_chan = ch; in_data = d;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    vld1 = out_valid;
    @(posedge clk); #5;
    vld2 = out_valid; res = out_data; rch = out_chan;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; wr_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] res;
    logic [1:0]  rch;
    bit v1, v2;
    in_chan = '0; in_data = '0; wr_addr = '0; wr_data = '0;
    do_reset();
    check(out_valid == 1'b0, "R1 reset out_valid", {31'd0, out_valid}, 0);

    for (int c = 0; c < 4; c++) begin
      run(2'(c), 24'hA00001 + 24'(c), res, rch, v1, v2);
      check(res == 24'hA00001 + 24'(c), "R1 passthrough after reset", {8'd0, res}, {8'd0, 24'hA00001 + 24'(c)});
    end

    for (int i = 0; i < NV; i++) begin
      logic [1:0] ch = 2'(i % 4);
      set_coef(ch, 1'b0, VEC[i][47:24]);
      set_coef(ch, 1'b1, VEC[i][23:0]);
      run(ch, VEC[i][71:48], res, rch, v1, v2);
      check(res == model(VEC[i][71:48], VEC[i][47:24], VEC[i][23:0]),
            $sformatf("R3 R4 R5 R6 vector %0d", i), {8'd0, res},
            {8'd0, model(VEC[i][71:48], VEC[i][47:24], VEC[i][23:0])});
    end

    // Spot values that pin down the corner behaviour explicitly.
    set_coef(2'd0, 1'b0, 24'h000000); set_coef(2'd0, 1'b1, 24'h400000);
    run(2'd0, 24'h000003, res, rch, v1, v2);
    check(res == 24'h000002, "R5 +1.5 rounds to 2", {8'd0, res}, 32'h2);
    run(2'd0, 24'hFFFFFD, res, rch, v1, v2);
    check(res == 24'hFFFFFF, "R5 -1.5 rounds to -1", {8'd0, res}, 32'hFFFFFF);
    set_coef(2'd0, 1'b1, 24'hFFFFFF);
    run(2'd0, 24'h400000, res, rch, v1, v2);
    check(res == 24'h7FFFFF, "R6 upper clamp", {8'd0, res}, 32'h7FFFFF);
    set_coef(2'd0, 1'b0, 24'h7FFFFF); set_coef(2'd0, 1'b1, 24'h800000);
    run(2'd0, 24'h800000, res, rch, v1, v2);
    check(res == 24'h800000, "R6 R3 lower clamp", {8'd0, res}, 32'h800000);
    set_coef(2'd0, 1'b1, 24'h000000);
    run(2'd0, 24'h7FFFFF, res, rch, v1, v2);
    check(res == 24'h000000, "R4 zero gain", {8'd0, res}, 32'h0);

    // R2: channel independence
    set_coef(2'd1, 1'b0, 24'h000000); set_coef(2'd1, 1'b1, 24'h800000);
    set_coef(2'd2, 1'b0, 24'h0001F4);
    run(2'd1, 24'h000400, res, rch, v1, v2);
    check(res == 24'h000400, "R2 other channel untouched", {8'd0, res}, 32'h400);

    // R7: upper half alone has no effect
    set_coef(2'd3, 1'b0, 24'h000000); set_coef(2'd3, 1'b1, 24'h800000);
    wr({2'd3, 1'b0, 1'b0}, 16'h0001);
    run(2'd3, 24'd1000, res, rch, v1, v2);
    check(res == 24'd1000, "R7 upper half staged only", {8'd0, res}, 32'd1000);
    wr({2'd3, 1'b0, 1'b1}, 16'h0000);
    run(2'd3, 24'd1000, res, rch, v1, v2);
    check(res == 24'd744, "R7 lower half commits", {8'd0, res}, 32'd744);

    // R8: coincident write applies from next sample
    wr({2'd1, 1'b0, 1'b0}, 16'h0000);
    in_valid = 1'b1; in_chan = 2'd1; in_data = 24'd100;
    wr_en = 1'b1; wr_addr = {2'd1, 1'b0, 1'b1}; wr_data = 16'h1000;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; wr_en = 1'b0;
    @(posedge clk); #5;
    check(out_data == 24'd100, "R8 coincident sample uses old offset", {8'd0, out_data}, 32'd100);
    @(negedge clk);
    run(2'd1, 24'd100, res, rch, v1, v2);
    check(res == 24'd84, "R8 next sample uses new offset", {8'd0, res}, 32'd84);

    // R9: latency, tag and streaming
    run(2'd3, 24'd5, res, rch, v1, v2);
    check(v1 == 1'b0, "R9 not valid after one clock", {31'd0, v1}, 0);
    check(v2 == 1'b1 && rch == 2'd3, "R9 valid after two clocks with tag", {29'd0, v2, rch}, {29'd0, 1'b1, 2'd3});
    in_valid = 1'b1; in_chan = 2'd1; in_data = 24'd200;
    @(posedge clk); @(negedge clk);
    in_chan = 2'd3; in_data = 24'd300;
    @(posedge clk); #5;
    check(out_valid && out_chan == 2'd1 && out_data == 24'd184, "R9 stream first",
          {6'd0, out_valid, out_chan, out_data}, {6'd0, 1'b1, 2'd1, 24'd184});
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #5;
    check(out_valid && out_chan == 2'd3 && out_data == 24'd44, "R9 stream second",
          {6'd0, out_valid, out_chan, out_data}, {6'd0, 1'b1, 2'd3, 24'd44});
    @(posedge clk); #5;
    check(!out_valid, "R9 valid drops after stream", {31'd0, out_valid}, 0);
    @(negedge clk);

    // R1: coefficients are volatile
    do_reset();
    for (int c = 0; c < 4; c++) begin
      run(2'(c), 24'h0ABCDE, res, rch, v1, v2);
      check(res == 24'h0ABCDE, "R1 passthrough after second reset", {8'd0, res}, 32'h0ABCDE);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule